// File: doc/BRIEF.md
# Serial configuration bitstream reader

This block is the readout side of a serial memory that holds an FPGA configuration image. On each rising clock edge it moves one bit further through its contents, most significant bit of each byte first. A bit counter selects the bit within the current byte. An address counter selects the byte. The current bit is presented on a data output with a separate drive-enable, which together model a three-state pad. Flow control is a plain level, not a handshake. The loading FPGA owns the clock, and the reader only pauses when its chip enable is high, its output enable is inactive, or readout mode is off.

One pin does two jobs. At its reset level it clears both counters at once, without waiting for a clock. At its other level it is the output enable. The reset level is chosen by a parameter. Once the last bit of the last byte has gone out, the reader stops driving and pulls its chain-enable output low. In a daisy chain that output feeds the chip enable of the next reader, so the stream continues with no gap.

The contents are computed rather than stored. Byte `a` holds `(a*37 + SEED) mod 256`, which gives a known image at any depth.

Top module: `serial_cfg_reader`

## Requirements
- R1: While `rst_oe` is at its reset level, both counters and the end-of-memory state clear at once. Both `dout_en` and `ceo_n` are then high-impedance and high respectively: `dout_en` is 0 and `ceo_n` is 1. After release, readout starts again at byte 0, bit 7.
- R2: A rising edge advances the position by one bit only when `ser_en`=1, `ce_n`=0 and the output enable is active. After bit 0 of a byte, the next edge moves to bit 7 of the next byte.
- R3: Bits leave most significant first. Byte `a` holds `(a*37 + SEED) mod 256`.
- R4: `dout_en` is 1 only when `ser_en`=1, `ce_n`=0, the output enable is active, and the end of memory has not been reached. At all other times the data output is treated as high-impedance.
- R5: While `ce_n`=1 the counters hold and `dout_en`=0. When `ce_n` returns low, readout resumes at the bit that was next before the pause.
- R6: While `ser_en`=0 the reader neither counts nor drives data, and `ceo_n` stays 1 regardless of `ce_n`.
- R7: The edge that consumes bit 0 of byte DEPTH-1 sets the end-of-memory state. The counters then hold at their final value and never wrap. No data is driven until the next reset.
- R8: After end of memory, `ceo_n` equals `ce_n` while `ser_en`=1. A reset returns `ceo_n` to 1, and it stays 1 until the whole memory has been read again.
- R9: With `RST_HIGH`=0, a low level on `rst_oe` resets the reader and a high level enables the output. With `RST_HIGH`=1, the two levels swap roles.
- R10: In a chain, where `ceo_n` of one reader drives `ce_n` of the next, the next reader drives its bit 7 of byte 0 in the cycle right after the last bit of the first reader. Only one reader ever drives at a time, and the combined stream contains every bit once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the loading device |
| rst_oe | input | 1 | Combined reset / output enable; the reset level is set by `RST_HIGH` |
| ce_n | input | 1 | Chip enable, active low |
| ser_en | input | 1 | Readout mode; must be 1 to count or drive |
| dout | output | 1 | Current configuration bit |
| dout_en | output | 1 | Pad drive enable for `dout`; 0 means high-impedance |
| ceo_n | output | 1 | Chain enable to the next reader, active low |

## Verification
The first test streams the whole image of a two-reader chain through one scoreboard. A mismatch there separates bit-order and content errors from counter-stepping errors. The stream is interrupted once by raising chip enable and once by dropping readout mode. Either kind of pause would show up as a skipped or repeated bit, which tells hold behaviour apart from free-running counting. Once the chain has finished, chip enable is toggled, readout mode is dropped, and a reset pulse is applied; together these walk the chain-enable sequence. A third reader built with the inverted reset polarity is streamed, reset and restarted, which shows whether the pin's roles follow the parameter.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int MULT   = 37;

  typedef logic [BIT_W-1:0]  bit_idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t image_byte(input logic [31:0] addr, input byte_t seed);
    logic [31:0] p;
    p = addr * 32'(MULT) + {24'b0, seed};
    return p[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/cfgrd_gate.sv
module cfgrd_gate #(
  parameter bit RST_HIGH = 1'b0
) (
  input  logic rst_oe,
  input  logic ce_n,
  input  logic ser_en,
  output logic rst_n_int,
  output logic step_en,
  output logic drive_ok
);
  // the pin is in its enable role whenever it is not at the reset level
  assign rst_n_int = rst_oe ^ RST_HIGH;
  assign drive_ok  = ser_en & ~ce_n & rst_n_int;
  assign step_en   = drive_ok;
endmodule

// File: rtl/cfgrd_counter.sv
module cfgrd_counter
  import cfgrd_pkg::*;
#(
  parameter int DEPTH  = 131072,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr_q,
  output bit_idx_t          bit_q,
  output logic              done_q
);
  localparam logic [ADDR_W-1:0] LAST     = ADDR_W'(DEPTH - 1);
  localparam bit_idx_t          BIT_LAST = bit_idx_t'(BYTE_W - 1);

  // bit_q counts 0..7 and selects bit (7 - bit_q), which makes the order MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (step_en && !done_q) begin
      if (bit_q == BIT_LAST) begin
        if (addr_q == LAST) begin
          done_q <= 1'b1;
        end else begin
          addr_q <= addr_q + 1'b1;
          bit_q  <= '0;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> (bit_q == $past(bit_q)) && (addr_q == $past(addr_q)));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !done_q && bit_q != BIT_LAST) |=> (bit_q == $past(bit_q) + 1'b1));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q && (addr_q == LAST) && (bit_q == BIT_LAST));
endmodule

// File: rtl/cfgrd_rom.sv
module cfgrd_rom
  import cfgrd_pkg::*;
#(
  parameter int    ADDR_W = 17,
  parameter byte_t SEED   = 8'h00
) (
  input  logic [ADDR_W-1:0] addr,
  input  bit_idx_t          bit_idx,
  output logic              bit_o
);
  byte_t cur;
  always_comb begin
    cur   = image_byte(32'(addr), SEED);
    bit_o = cur[bit_idx_t'(BYTE_W - 1) - bit_idx];
  end
endmodule

// File: rtl/serial_cfg_reader.sv
module serial_cfg_reader
  import cfgrd_pkg::*;
#(
  parameter int    DEPTH    = 131072,
  parameter byte_t SEED     = 8'h00,
  parameter bit    RST_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_oe,
  input  logic ce_n,
  input  logic ser_en,
  output logic dout,
  output logic dout_en,
  output logic ceo_n
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              rst_n_int, step_en, drive_ok, done;
  logic [ADDR_W-1:0] addr;
  bit_idx_t          bit_idx;

  cfgrd_gate #(.RST_HIGH(RST_HIGH)) u_gate (
    .rst_oe(rst_oe), .ce_n(ce_n), .ser_en(ser_en),
    .rst_n_int(rst_n_int), .step_en(step_en), .drive_ok(drive_ok)
  );

  cfgrd_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .step_en(step_en),
    .addr_q(addr), .bit_q(bit_idx), .done_q(done)
  );

  cfgrd_rom #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
    .addr(addr), .bit_idx(bit_idx), .bit_o(dout)
  );

  assign dout_en = drive_ok & ~done;
  assign ceo_n   = ~(done & ~ce_n & ser_en);

  a_r4_drive_needs_enable: assert property (@(posedge clk) disable iff (!rst_n_int)
    dout_en |-> (!ce_n && ser_en));

  a_r8_chain_only_at_end: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ceo_n |-> (addr == LAST) && (bit_idx == bit_idx_t'(BYTE_W - 1)));
endmodule

// File: tb/serial_cfg_reader_test.sv
`timescale 1ns/1ps
module serial_cfg_reader_test;
  localparam int DA = 6, DB = 4, DI = 4;
  localparam logic [7:0] SA = 8'h11, SB = 8'h5C, SI = 8'hA7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pin_a, ce_a, ser, pin_i;
  logic d_a, en_a, ceo_a, d_b, en_b, ceo_b, d_i, en_i, ceo_i;
  logic mon_on;
  int   checks = 0, errors = 0, popped = 0;
  bit   fin = 1'b0;
  bit   expq[$];

  serial_cfg_reader #(.DEPTH(DA), .SEED(SA), .RST_HIGH(1'b0)) uut (
    .clk(clk), .rst_oe(pin_a), .ce_n(ce_a), .ser_en(ser),
    .dout(d_a), .dout_en(en_a), .ceo_n(ceo_a));

  serial_cfg_reader #(.DEPTH(DB), .SEED(SB), .RST_HIGH(1'b0)) nxt (
    .clk(clk), .rst_oe(pin_a), .ce_n(ceo_a), .ser_en(ser),
    .dout(d_b), .dout_en(en_b), .ceo_n(ceo_b));

  serial_cfg_reader #(.DEPTH(DI), .SEED(SI), .RST_HIGH(1'b1)) inv (
    .clk(clk), .rst_oe(pin_i), .ce_n(1'b0), .ser_en(1'b1),
    .dout(d_i), .dout_en(en_i), .ceo_n(ceo_i));

  function automatic bit expbit(input logic [7:0] seed, input int k);
    int v;
    v = ((k / 8) * 37 + seed) % 256;
    return v[7 - (k % 8)];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_stream(input logic [7:0] seed, input int depth);
    for (int k = 0; k < depth * 8; k++) expq.push_back(expbit(seed, k));
  endtask

  // scoreboard monitor for the shared data line of the chain
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (en_a && en_b) begin
          chk(1'b0, "R10 two drivers", 2, 1);
        end else if (en_a || en_b) begin
          bit got, want;
          got = en_a ? d_a : d_b;
          if (expq.size() == 0) begin
            chk(1'b0, "R10 extra data bit", popped, (DA + DB) * 8);
          end else begin
            want = expq.pop_front();
            chk(got == want, $sformatf("R2 R3 bit %0d", popped), got, want);
            popped++;
          end
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_a = 1'b0; ce_a = 1'b0; ser = 1'b1; pin_i = 1'b1; mon_on = 1'b0;
    push_stream(SA, DA);
    push_stream(SB, DB);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!en_a && !en_b, "R1 no drive in reset", en_a, 0);
    chk(ceo_a == 1'b1, "R1 chain high in reset", ceo_a, 1);
    chk(!en_i, "R9 inverted pin high is reset", en_i, 0);

    @(posedge clk); #1 pin_a = 1'b1; mon_on = 1'b1;
    repeat (10) @(posedge clk);
    #1 ce_a = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!en_a, "R5 standby no drive", en_a, 0);
      chk(ceo_a == 1'b1, "R5 chain high mid stream", ceo_a, 1);
    end
    @(posedge clk); #1 ce_a = 1'b0;
    repeat (5) @(posedge clk);
    #1 ser = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(!en_a, "R6 no drive with mode off", en_a, 0);
    end
    @(posedge clk); #1 ser = 1'b1;

    for (int w = 0; w < 200; w++) begin
      @(negedge clk);
      if (!ceo_a) break;
    end
    #1;
    chk(ceo_a == 1'b0, "R7 chain low at end", ceo_a, 0);
    chk(popped == DA * 8 + 1, "R10 next reader starts at once", popped, DA * 8 + 1);
    chk(!en_a, "R4 no drive after end", en_a, 0);

    repeat (DB * 8 + 3) @(posedge clk);
    @(negedge clk); #1;
    chk(!en_a && !en_b, "R7 no wrap, bus idle", en_a + en_b, 0);
    chk(ceo_b == 1'b0, "R8 second chain low", ceo_b, 0);
    chk(expq.size() == 0 && popped == (DA + DB) * 8, "R10 full stream", popped, (DA + DB) * 8);

    @(posedge clk); #1 ce_a = 1'b1;
    @(negedge clk);
    chk(ceo_a == 1'b1, "R8 follows ce high", ceo_a, 1);
    @(posedge clk); #1 ce_a = 1'b0;
    @(negedge clk);
    chk(ceo_a == 1'b0, "R8 follows ce low", ceo_a, 0);
    @(posedge clk); #1 ser = 1'b0;
    @(negedge clk);
    chk(ceo_a == 1'b1, "R6 chain high with mode off", ceo_a, 1);
    @(posedge clk); #1 ser = 1'b1;

    mon_on = 1'b0;
    @(posedge clk); #1 pin_a = 1'b0;
    @(negedge clk);
    chk(ceo_a == 1'b1, "R8 reset raises chain", ceo_a, 1);
    chk(!en_a, "R1 reset stops drive", en_a, 0);
    @(posedge clk); #1 pin_a = 1'b1;
    @(negedge clk);
    chk(ceo_a == 1'b1 && ceo_b == 1'b1, "R8 chain stays high after reset", ceo_a, 1);
    chk(en_a && d_a == expbit(SA, 0), "R1 restart at byte 0 bit 7", d_a, expbit(SA, 0));

    @(posedge clk); #1 pin_i = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(en_i && d_i == expbit(SI, k), $sformatf("R9 inverted stream bit %0d", k), d_i, expbit(SI, k));
      @(posedge clk);
    end
    #1 pin_i = 1'b1;
    @(negedge clk);
    chk(!en_i, "R9 pin high resets", en_i, 0);
    @(posedge clk); #1 pin_i = 1'b0;
    @(negedge clk);
    chk(en_i && d_i == expbit(SI, 0), "R9 restart after reset", d_i, expbit(SI, 0));

    fin = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule